// File: doc/BRIEF.md
# I2C Pointer-Addressed Register Slave

This block is the two-wire serial slave front end of a data converter with four 16-bit registers. A one-byte index register, loaded only by write transactions, chooses the register that later reads return. The index survives from one transaction to the next, so a host can poll a single register over and over by issuing reads alone. Every write transaction carries the index byte first. Any data that follows it is taken as 16-bit words, most significant byte first.

The block samples the serial clock and data lines with the system clock. It acknowledges only its own 7-bit address. Acknowledge bits and read data are driven through an open-drain enable. The control register has a start/status bit. Writing 1 to it while the device sits in power-down mode sends a one-cycle start pulse to an external conversion engine. Reading it returns 0 until that engine reports completion. On completion, the engine's result is captured into the read-only result register.

Top module: `i2c_ptr_regslave`

## Requirements
- R1: A transaction whose 7-bit address differs from DEV_ADDR (default 0x48) gets no acknowledge (data line stays released in the 9th clock), and it changes no register and not the index.
- R2: The index (reset value 0) selects the register every read returns. It is kept across transactions, so repeated reads with no index byte return the same register.
- R3: An index byte with any of bits 7..2 set is acknowledged but leaves the index unchanged. Bits 1..0 select the register: 0 result, 1 control, 2 lower limit, 3 upper limit.
- R4: A write that stops right after the index byte updates only the index.
- R5: Data is written MSB first, and a register changes only once both bytes of a word are received. A write cut off after one data byte leaves the register unchanged.
- R6: The result register reads 0 after reset and ignores writes.
- R7: After reset the control register reads 0x8583, the lower limit 0x8000 and the upper limit 0x7FFF, and the data line is released.
- R8: Writing a word with bit 15 = 1 to the control register produces exactly one single-cycle start pulse. This happens only when the stored mode bit 8 was 1 before the write and no conversion is running. Bit 15 = 0 starts nothing. Bits 14..0 are stored as written.
- R9: Control bit 15 reads 0 from the start pulse until a done pulse. On the done pulse the result input is captured into the result register and bit 15 reads 1 again.
- R10: Reads return the MSB then the LSB of the selected register. Further bytes in the same read repeat that order.
- R11: Every byte written after a matching address is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| conv_done | input | 1 | One-cycle completion pulse from the conversion engine |
| conv_result | input | 16 | Two's complement conversion result, valid with conv_done |

## Verification
The register path is driven with reads that carry no index byte, each right after a different index write. Matching read-back shows that the index alone routes the data, and that it persists. Writes are sent in several shapes: complete words, an index-only write, a write cut off after one data byte, an index byte with high bits set, and a transaction to a foreign address. Each shape changes a different part of the state, or none of it, and a following read exposes which. The control register is written with the start bit set and clear, in both modes, and again while a conversion is running. This separates a start issued from idle power-down from one that must be suppressed. The status bit and the captured result are then checked after a completion pulse.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int SEL_W  = 2;

    localparam int CTRL_GO_BIT   = 15;
    localparam int CTRL_MODE_BIT = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } eng_state_t;

    typedef enum logic [1:0] {
        PH_INDEX,
        PH_HIGH,
        PH_LOW
    } wr_phase_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_RESULT = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_LIM_LO = 2'd2,
        SEL_LIM_HI = 2'd3
    } reg_sel_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    typedef struct packed {
        logic                    valid;
        wr_phase_t               phase;
        logic [BYTE_W-1:0]       data;
    } wr_item_t;

    function automatic logic index_byte_ok(input logic [BYTE_W-1:0] b);
        return (b[BYTE_W-1:SEL_W] == '0);
    endfunction

    function automatic wr_phase_t next_phase(input wr_phase_t p);
        case (p)
            PH_INDEX: return PH_HIGH;
            PH_HIGH:  return PH_LOW;
            default:  return PH_HIGH;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events
    import i2c_ptr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_now;
    logic                   sda_now;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        scl_pipe[0] <= 1'b1;
                        sda_pipe[0] <= 1'b1;
                    end else begin
                        scl_pipe[0] <= scl_i;
                        sda_pipe[0] <= sda_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        scl_pipe[s] <= 1'b1;
                        sda_pipe[s] <= 1'b1;
                    end else begin
                        scl_pipe[s] <= scl_pipe[s-1];
                        sda_pipe[s] <= sda_pipe[s-1];
                    end
                end
            end
        end
    endgenerate

    assign scl_now = scl_pipe[SYNC_STAGES-1];
    assign sda_now = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    always_comb begin
        ev.rise  = scl_now & ~scl_prev;
        ev.fall  = ~scl_now & scl_prev;
        ev.start = scl_now & scl_prev & sda_prev & ~sda_now;
        ev.stop  = scl_now & scl_prev & ~sda_prev & sda_now;
        ev.sda   = sda_now;
    end

    a_r1_no_double_edge: assert property (@(posedge clk) disable iff (rst)
        ev.rise |=> !ev.rise);

endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
    import i2c_ptr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [WORD_W-1:0] rd_word,
    output wr_item_t          wr,
    output logic              sda_oe
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    eng_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] low_hold;
    logic              is_read;
    logic              low_next;
    logic              host_nack;
    wr_phase_t         phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            low_hold  <= '0;
            is_read   <= 1'b0;
            low_next  <= 1'b0;
            host_nack <= 1'b1;
            phase     <= PH_INDEX;
            sda_oe    <= 1'b0;
            wr        <= '0;
        end else begin
            wr.valid <= 1'b0;
            if (ev.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (ev.rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev.fall && bit_cnt == CNT_W'(BYTE_W)) begin
                            if (rx_sh[BYTE_W-1:1] == DEV_ADDR) begin
                                sda_oe  <= 1'b1;
                                is_read <= rx_sh[0];
                                state   <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.fall) begin
                            bit_cnt <= '0;
                            if (is_read) begin
                                tx_sh    <= rd_word[WORD_W-1:BYTE_W];
                                low_hold <= rd_word[BYTE_W-1:0];
                                low_next <= 1'b1;
                                sda_oe   <= ~rd_word[WORD_W-1];
                                state    <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= PH_INDEX;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        if (ev.rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev.fall && bit_cnt == CNT_W'(BYTE_W)) begin
                            sda_oe   <= 1'b1;
                            wr.valid <= 1'b1;
                            wr.data  <= rx_sh;
                            wr.phase <= phase;
                            phase    <= next_phase(phase);
                            state    <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (ev.rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev.fall) begin
                            if (bit_cnt == CNT_W'(BYTE_W)) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.rise) begin
                            host_nack <= ev.sda;
                        end else if (ev.fall) begin
                            if (host_nack) begin
                                state <= ST_IDLE;
                            end else begin
                                bit_cnt <= '0;
                                state   <= ST_RD;
                                if (low_next) begin
                                    tx_sh    <= low_hold;
                                    sda_oe   <= ~low_hold[BYTE_W-1];
                                    low_next <= 1'b0;
                                end else begin
                                    tx_sh    <= rd_word[WORD_W-1:BYTE_W];
                                    low_hold <= rd_word[BYTE_W-1:0];
                                    sda_oe   <= ~rd_word[WORD_W-1];
                                    low_next <= 1'b1;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: an idle slave never holds the data line
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R10: the host's acknowledge slot is left free
    a_r10_host_ack_free: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_ACK) |-> !sda_oe);

    // R11: a delivered byte is followed by an acknowledge
    a_r11_ack_follows_byte: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && !ev.start && !ev.stop) |-> sda_oe);

endmodule

// File: rtl/ptr_reg_bank.sv
module ptr_reg_bank
    import i2c_ptr_pkg::*;
#(
    parameter logic [WORD_W-1:0] CTRL_RESET   = 16'h8583,
    parameter logic [WORD_W-1:0] LIM_LO_RESET = 16'h8000,
    parameter logic [WORD_W-1:0] LIM_HI_RESET = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_item_t          wr,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] conv_result,
    output logic [WORD_W-1:0] rd_word,
    output logic              conv_start
);

    localparam int NUM_LIM = 2;

    reg_sel_t            index_q;
    logic [BYTE_W-1:0]   high_q;
    logic [WORD_W-2:0]   ctrl_q;
    logic [WORD_W-1:0]   result_q;
    logic [WORD_W-1:0]   lim_q [NUM_LIM];
    logic                busy_q;
    logic [WORD_W-1:0]   word_in;
    logic                lim_we [NUM_LIM];

    assign word_in = {high_q, wr.data};

    generate
        for (genvar k = 0; k < NUM_LIM; k++) begin : g_lim
            localparam logic [WORD_W-1:0] RST_V = (k == 0) ? LIM_LO_RESET : LIM_HI_RESET;
            localparam reg_sel_t MY_SEL = (k == 0) ? SEL_LIM_LO : SEL_LIM_HI;
            assign lim_we[k] = wr.valid && wr.phase == PH_LOW && index_q == MY_SEL;
            always_ff @(posedge clk) begin
                if (rst) lim_q[k] <= RST_V;
                else if (lim_we[k]) lim_q[k] <= word_in;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q    <= SEL_RESULT;
            high_q     <= '0;
            ctrl_q     <= CTRL_RESET[WORD_W-2:0];
            result_q   <= '0;
            busy_q     <= 1'b0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            if (busy_q && conv_done) begin
                result_q <= conv_result;
                busy_q   <= 1'b0;
            end
            if (wr.valid) begin
                case (wr.phase)
                    PH_INDEX: if (index_byte_ok(wr.data)) index_q <= reg_sel_t'(wr.data[SEL_W-1:0]);
                    PH_HIGH:  high_q <= wr.data;
                    default: begin
                        if (index_q == SEL_CTRL) begin
                            ctrl_q <= word_in[WORD_W-2:0];
                            if (word_in[CTRL_GO_BIT] && ctrl_q[CTRL_MODE_BIT] && !busy_q) begin
                                busy_q     <= 1'b1;
                                conv_start <= 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        case (index_q)
            SEL_RESULT: rd_word = result_q;
            SEL_CTRL:   rd_word = {~busy_q, ctrl_q};
            SEL_LIM_LO: rd_word = lim_q[0];
            default:    rd_word = lim_q[1];
        endcase
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    a_r8_status_busy: assert property (@(posedge clk) disable iff (rst)
        (conv_start && !conv_done) |=> (index_q != SEL_CTRL) || !rd_word[CTRL_GO_BIT]);

    a_r9_done_frees: assert property (@(posedge clk) disable iff (rst)
        (busy_q && conv_done) |=> !busy_q);

    a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
        !(busy_q && conv_done) |=> $stable(result_q));

    a_r3_bad_index_kept: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.phase == PH_INDEX && !index_byte_ok(wr.data)) |=> $stable(index_q));

    a_r5_high_no_commit: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.phase == PH_HIGH) |=> ($stable(ctrl_q) && $stable(lim_q[0]) && $stable(lim_q[1])));

endmodule

// File: rtl/i2c_ptr_regslave.sv
module i2c_ptr_regslave
    import i2c_ptr_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR     = 7'h48,
    parameter int                SYNC_STAGES  = 2,
    parameter logic [WORD_W-1:0] CTRL_RESET   = 16'h8583,
    parameter logic [WORD_W-1:0] LIM_LO_RESET = 16'h8000,
    parameter logic [WORD_W-1:0] LIM_HI_RESET = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] conv_result
);

    line_ev_t          ev;
    wr_item_t          wr;
    logic [WORD_W-1:0] rd_word;

    i2c_line_events #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_line (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_byte_fsm #(
        .DEV_ADDR(DEV_ADDR)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_word (rd_word),
        .wr      (wr),
        .sda_oe  (sda_oe)
    );

    ptr_reg_bank #(
        .CTRL_RESET  (CTRL_RESET),
        .LIM_LO_RESET(LIM_LO_RESET),
        .LIM_HI_RESET(LIM_HI_RESET)
    ) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .rd_word     (rd_word),
        .conv_start  (conv_start)
    );

endmodule

// File: tb/i2c_ptr_regslave_tb_top.sv
module i2c_ptr_regslave_tb_top;

    localparam int Q = 10;
    localparam logic [6:0] ME    = 7'h48;
    localparam logic [6:0] OTHER = 7'h49;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        conv_start;
    logic        conv_done = 1'b0;
    logic [15:0] conv_result = '0;
    logic        sda_bus;

    int n_tests = 0;
    int n_fail  = 0;
    int n_pulses = 0;
    int long_pulse = 0;
    logic prev_start = 1'b0;
    bit   finished = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] obs_q[$];

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_ptr_regslave dut_i (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .conv_start  (conv_start),
        .conv_done   (conv_done),
        .conv_result (conv_result)
    );

    always @(negedge clk) begin
        if (conv_start) n_pulses++;
        if (conv_start && prev_start) long_pulse++;
        prev_start = conv_start;
    end

    // monitor: pops observed read bytes and compares them against expectations
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                exp_t       e;
                logic [7:0] o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                n_tests++;
                if (o !== e.val) begin
                    n_fail++;
                    $display("FAIL %s read byte actual=%h expected=%h", e.tag, o, e.val);
                end
            end
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack_n);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(ack_n);
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            recv_bit(b);
            d[i] = b;
        end
        send_bit(last);
    endtask

    // write transaction: address, then n bytes; checks every acknowledge
    task automatic write_seq(input logic [6:0] a, input int n, input logic [7:0] b0,
                             input logic [7:0] b1, input logic [7:0] b2,
                             input logic exp_addr_nack, input string req);
        logic ack_n;
        logic [7:0] bytes[3];
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
        bus_start();
        send_byte({a, 1'b0}, ack_n);
        check(req, {15'd0, ack_n}, {15'd0, exp_addr_nack});
        if (!exp_addr_nack) begin
            for (int i = 0; i < n; i++) begin
                send_byte(bytes[i], ack_n);
                check("R11 data byte ack", {15'd0, ack_n}, 16'd0);
            end
        end
        bus_stop();
    endtask

    // driver: pushes expected bytes, then performs the read
    task automatic read_seq(input int n, input logic [15:0] w, input string req);
        logic ack_n;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.val = (i % 2 == 0) ? w[15:8] : w[7:0];
            e.tag = req;
            exp_q.push_back(e);
        end
        bus_start();
        send_byte({ME, 1'b1}, ack_n);
        check("R1 own read address ack", {15'd0, ack_n}, 16'd0);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            recv_byte(i == n - 1, d);
            obs_q.push_back(d);
        end
        bus_stop();
    endtask

    task automatic set_word(input logic [1:0] idx, input logic [15:0] w, input string req);
        write_seq(ME, 3, {6'd0, idx}, w[15:8], w[7:0], 1'b0, req);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 reset data line released", {15'd0, sda_oe}, 16'd0);
        check("R8 reset no start", {15'd0, conv_start}, 16'd0);

        // R2 R6: index resets to result register, which reads 0
        read_seq(2, 16'h0000, "R6 result after reset");
        // R4: index-only write
        write_seq(ME, 1, 8'h01, 8'h00, 8'h00, 1'b0, "R4 index write ack");
        read_seq(2, 16'h8583, "R7 control reset");
        read_seq(2, 16'h8583, "R2 repeated read");
        write_seq(ME, 1, 8'h02, 8'h00, 8'h00, 1'b0, "R4 index write ack");
        read_seq(2, 16'h8000, "R7 lower limit reset");
        write_seq(ME, 1, 8'h03, 8'h00, 8'h00, 1'b0, "R4 index write ack");
        read_seq(2, 16'h7FFF, "R7 upper limit reset");

        // R5: full word write
        set_word(2'd2, 16'h1234, "R5 word write ack");
        read_seq(2, 16'h1234, "R5 full word stored");
        // R5: cut off after one data byte
        write_seq(ME, 2, 8'h02, 8'hAB, 8'h00, 1'b0, "R5 partial write ack");
        read_seq(2, 16'h1234, "R5 partial write ignored");

        // R1: foreign address is not acknowledged and changes nothing
        write_seq(OTHER, 3, 8'h03, 8'hFF, 8'hFF, 1'b1, "R1 foreign address nack");
        read_seq(2, 16'h1234, "R1 index and data unchanged");

        // R3: index byte with high bits set
        write_seq(ME, 1, 8'h05, 8'h00, 8'h00, 1'b0, "R3 bad index acked");
        read_seq(2, 16'h1234, "R3 index kept");

        // R6: result register ignores writes
        set_word(2'd0, 16'h5555, "R6 write ack");
        read_seq(2, 16'h0000, "R6 result read-only");

        // R10: multi-byte read repeats MSB/LSB
        write_seq(ME, 1, 8'h02, 8'h00, 8'h00, 1'b0, "R4 index write ack");
        read_seq(4, 16'h1234, "R10 byte order repeat");

        // R8: start bit clear, mode set -> no start
        set_word(2'd1, 16'h0583, "R8 ctrl write ack");
        read_seq(2, 16'h8583, "R8 go=0 stored");
        check("R8 go=0 no start", n_pulses[15:0], 16'd0);
        set_word(2'd1, 16'h0483, "R8 ctrl write ack");
        read_seq(2, 16'h8483, "R8 mode cleared stored");
        set_word(2'd1, 16'h8483, "R8 ctrl write ack");
        read_seq(2, 16'h8483, "R8 go in continuous mode");
        check("R8 continuous mode no start", n_pulses[15:0], 16'd0);
        set_word(2'd1, 16'h0583, "R8 ctrl write ack");
        set_word(2'd1, 16'hC583, "R8 ctrl write ack");
        check("R8 one start pulse", n_pulses[15:0], 16'd1);
        check("R8 pulse single cycle", long_pulse[15:0], 16'd0);
        read_seq(2, 16'h4583, "R9 status busy");
        set_word(2'd1, 16'h8583, "R8 ctrl write ack");
        check("R8 no start while busy", n_pulses[15:0], 16'd1);
        read_seq(2, 16'h0583, "R9 still busy");

        // R9: completion
        @(negedge clk);
        conv_result = 16'hBEEF;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        conv_result = 16'h0000;
        read_seq(2, 16'h8583, "R9 status idle after done");
        write_seq(ME, 1, 8'h00, 8'h00, 8'h00, 1'b0, "R4 index write ack");
        read_seq(2, 16'hBEEF, "R9 result captured");

        repeat (5) @(negedge clk);
        if (exp_q.size() != 0 || obs_q.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL scoreboard leftover actual=%0d expected=%0d", exp_q.size() + obs_q.size(), 0);
        end
        finish_run();
    end

endmodule